// File: doc/BRIEF.md
# Dual-Mode Host Command Byte Port

This block is the receiving end of a host command port. A host hands it command bytes either over a three-wire serial link (chip select, clock, data) or over an 8-bit parallel bus with write strobes. A static mode input picks the link type. In serial mode the two most significant bus pins become the serial data and serial clock inputs. All host pins are asynchronous to the block. They pass through two-flop synchronisers, and every edge is detected in the system clock domain.

In serial mode the block does not need to be told which clock edge to use. When chip select goes low it looks at the serial clock level. A low idle clock means bits are taken on rising clock edges, and a high idle clock means bits are taken on falling edges. That choice holds until chip select is released. Bits arrive most significant first. Each completed byte is presented on `byte_o` with a one-cycle `byte_vld_o` strobe. In parallel mode the bus is captured when a write strobe returns high. The command write strobe and the separate data-write strobe are told apart by `byte_kind_o`. A read strobe produces a one-cycle request pulse. While chip select is high, none of the strobes has any effect.

Top module: `hostcmd_port`

## Requirements
- R1: During and immediately after reset, `byte_vld_o` and `rd_pulse_o` are 0 and `byte_o` is 0x00.
- R2: In serial mode (`mode_serial_i`=1, `bus_i[7]`=data, `bus_i[6]`=clock), if the clock is low when `cs_n_i` falls, a data bit is taken on every rising clock edge. Bits are taken most significant first. After each eighth bit, the byte appears on `byte_o` with `byte_kind_o`=0 and a `byte_vld_o` pulse exactly one system clock long.
- R3: In serial mode, if the clock is high when `cs_n_i` falls, a data bit is taken on every falling clock edge, with the same byte assembly as R2.
- R4: The edge choice made when `cs_n_i` falls stays fixed for all bytes of that transaction, until `cs_n_i` rises.
- R5: If `cs_n_i` rises before a byte is complete, the partial bits are dropped and no byte is produced. The next transaction starts from bit 0.
- R6: In parallel mode (`mode_serial_i`=0), a rising edge of `wr_n_i` while `cs_n_i` is low captures `bus_i` onto `byte_o` with `byte_kind_o`=0 and a one-cycle `byte_vld_o`.
- R7: In parallel mode, a rising edge of `dw_n_i` while `cs_n_i` is low captures `bus_i` with `byte_kind_o`=1. If both strobes rise in the same cycle, a single byte is produced with `byte_kind_o`=0.
- R8: While `cs_n_i` is high, the strobes `wr_n_i`, `dw_n_i` and `rd_n_i`, and serial clock activity, produce no byte, no read pulse and no change in serial bit state.
- R9: A falling edge of `rd_n_i` while `cs_n_i` is low produces a `rd_pulse_o` exactly one system clock long.
- R10: In serial mode, the write strobes produce no byte. In parallel mode, toggling `bus_i[6]` and `bus_i[7]` without write strobes produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial_i | input | 1 | 1 = serial link, 0 = parallel bus (static) |
| cs_n_i | input | 1 | Chip select, active low |
| wr_n_i | input | 1 | Command write strobe, active low |
| dw_n_i | input | 1 | Data-write strobe, active low, idles high |
| rd_n_i | input | 1 | Read strobe, active low, idles high |
| bus_i | input | 8 | Parallel data; bit 7 = serial data, bit 6 = serial clock in serial mode |
| byte_o | output | 8 | Last received byte |
| byte_kind_o | output | 1 | 0 = command byte, 1 = data-write byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| rd_pulse_o | output | 1 | One-cycle read request |

## Verification
Most internal faults in this block show up as a wrong byte value or a byte count that is off by one. The block has three main pieces of state: the captured edge polarity, the bit counter, and the shift register. A wrong polarity moves every bit by half a serial clock period, and the byte differs from the expected value as soon as its strobe fires, about four system clocks after the eighth serial edge. A counter that is not cleared on chip-select release shows up on the next transaction, as an early strobe with a shifted value. A gating fault shows up as an extra `byte_vld_o` or `rd_pulse_o` within four cycles of a strobe that was sent while deselected.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    typedef enum logic {
        KIND_CMD  = 1'b0,
        KIND_DATA = 1'b1
    } byte_kind_e;

    typedef enum logic {
        SAMPLE_RISE = 1'b0,
        SAMPLE_FALL = 1'b1
    } sample_edge_e;

    typedef struct packed {
        logic [7:0] data;
        byte_kind_e kind;
    } byte_evt_t;

    // picks the active serial clock edge for the chosen polarity
    function automatic logic edge_hit(sample_edge_e sel, logic rise, logic fall);
        return (sel == SAMPLE_FALL) ? fall : rise;
    endfunction

    // polarity chosen from the idle clock level at select assertion
    function automatic sample_edge_e pick_edge(logic sclk_level);
        return sclk_level ? SAMPLE_FALL : SAMPLE_RISE;
    endfunction

endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hcp_serial_rx.sv
module hcp_serial_rx
    import hcp_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cs_low,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sdi,
    output logic             vld,
    output logic [DATA_W-1:0] data,
    output logic             active_o,
    output sample_edge_e     pol_o
);
    logic               active;
    sample_edge_e       pol;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-2:0]  shreg;
    logic               hit;

    assign hit = active && edge_hit(pol, sclk_rise, sclk_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pol    <= SAMPLE_RISE;
            cnt    <= '0;
            shreg  <= '0;
            vld    <= 1'b0;
            data   <= '0;
        end else begin
            vld <= 1'b0;
            if (!en || cs_rise || !cs_low) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (cs_fall) begin
                active <= 1'b1;
                pol    <= pick_edge(sclk);
                cnt    <= '0;
            end else if (hit) begin
                shreg <= {shreg[DATA_W-3:0], sdi};
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    cnt  <= '0;
                    vld  <= 1'b1;
                    data <= {shreg, sdi};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign active_o = active;
    assign pol_o    = pol;
endmodule

// File: rtl/hcp_par_rx.sv
module hcp_par_rx
    import hcp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cs_low,
    input  logic              wr_rise,
    input  logic              dw_rise,
    input  logic              rd_fall,
    input  logic [DATA_W-1:0] bus,
    output logic              vld,
    output logic [DATA_W-1:0] data,
    output byte_kind_e        kind,
    output logic              rd_pulse
);
    logic take_wr, take_dw;

    assign take_wr = en && cs_low && wr_rise;
    assign take_dw = en && cs_low && dw_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= 1'b0;
            data     <= '0;
            kind     <= KIND_CMD;
            rd_pulse <= 1'b0;
        end else begin
            vld      <= take_wr || take_dw;
            rd_pulse <= cs_low && rd_fall;
            if (take_wr) begin
                data <= bus;
                kind <= KIND_CMD;
            end else if (take_dw) begin
                data <= bus;
                kind <= KIND_DATA;
            end
        end
    end
endmodule

// File: rtl/hostcmd_port.sv
module hostcmd_port
    import hcp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_serial_i,
    input  logic              cs_n_i,
    input  logic              wr_n_i,
    input  logic              dw_n_i,
    input  logic              rd_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_kind_o,
    output logic              byte_vld_o,
    output logic              rd_pulse_o
);
    localparam int SDI_IDX  = DATA_W - 1;
    localparam int SCLK_IDX = DATA_W - 2;
    localparam int CTL_W    = 5;
    localparam int SYNC_W   = DATA_W + CTL_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 4'b1111, {DATA_W{1'b0}}};

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              mode_s, rd_s, dw_s, wr_s, cs_s;
    logic [DATA_W-1:0] bus_s;

    assign raw_in = {mode_serial_i, rd_n_i, dw_n_i, wr_n_i, cs_n_i, bus_i};

    hcp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );

    assign {mode_s, rd_s, dw_s, wr_s, cs_s, bus_s} = sync_out;

    // previous levels for edge detection: {rd, dw, wr, cs, sclk}
    logic [4:0] prev_q;
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 5'b11110;
        else     prev_q <= {rd_s, dw_s, wr_s, cs_s, bus_s[SCLK_IDX]};
    end

    logic cs_low, cs_fall, cs_rise, wr_rise, dw_rise, rd_fall, sclk_rise, sclk_fall;
    assign cs_low    = !cs_s;
    assign cs_fall   = !cs_s &&  prev_q[1];
    assign cs_rise   =  cs_s && !prev_q[1];
    assign wr_rise   =  wr_s && !prev_q[2];
    assign dw_rise   =  dw_s && !prev_q[3];
    assign rd_fall   = !rd_s &&  prev_q[4];
    assign sclk_rise =  bus_s[SCLK_IDX] && !prev_q[0];
    assign sclk_fall = !bus_s[SCLK_IDX] &&  prev_q[0];

    logic              ser_vld, ser_active;
    logic [DATA_W-1:0] ser_data;
    sample_edge_e      ser_pol;

    hcp_serial_rx #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst(rst), .en(mode_s),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk(bus_s[SCLK_IDX]), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi(bus_s[SDI_IDX]),
        .vld(ser_vld), .data(ser_data), .active_o(ser_active), .pol_o(ser_pol)
    );

    logic              par_vld, rd_pulse;
    logic [DATA_W-1:0] par_data;
    byte_kind_e        par_kind;

    hcp_par_rx #(.DATA_W(DATA_W)) u_par (
        .clk(clk), .rst(rst), .en(!mode_s), .cs_low(cs_low),
        .wr_rise(wr_rise), .dw_rise(dw_rise), .rd_fall(rd_fall),
        .bus(bus_s), .vld(par_vld), .data(par_data), .kind(par_kind),
        .rd_pulse(rd_pulse)
    );

    logic [DATA_W-1:0] byte_q;
    byte_kind_e        kind_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            kind_q <= KIND_CMD;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= ser_vld || par_vld;
            if (ser_vld) begin
                byte_q <= ser_data;
                kind_q <= KIND_CMD;
            end else if (par_vld) begin
                byte_q <= par_data;
                kind_q <= par_kind;
            end
        end
    end

    assign byte_o      = byte_q;
    assign byte_kind_o = kind_q;
    assign byte_vld_o  = vld_q;
    assign rd_pulse_o  = rd_pulse;
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker (
    input logic clk,
    input logic rst,
    input logic cs_low,
    input logic mode_s,
    input logic wr_rise,
    input logic ser_vld,
    input logic par_vld,
    input logic par_kind,
    input logic rd_pulse,
    input logic byte_vld,
    input logic ser_active,
    input logic ser_pol
);
    assert_vld_single_R2: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    assert_pol_held_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_active && $past(ser_active)) |-> (ser_pol == $past(ser_pol)));

    assert_wr_kind_R6: assert property (@(posedge clk) disable iff (rst)
        (par_vld && !par_kind) |-> $past(wr_rise));

    assert_ser_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ser_vld |-> $past(cs_low));

    assert_par_gate_R8: assert property (@(posedge clk) disable iff (rst)
        par_vld |-> $past(cs_low));

    assert_rd_gate_R9: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |-> ($past(cs_low) && !$past(rd_pulse)));

    assert_par_mode_R10: assert property (@(posedge clk) disable iff (rst)
        par_vld |-> !$past(mode_s));

    assert_ser_mode_R10: assert property (@(posedge clk) disable iff (rst)
        ser_vld |-> $past(mode_s));
endmodule

bind hostcmd_port hcp_checker u_chk (
    .clk(clk), .rst(rst), .cs_low(cs_low), .mode_s(mode_s), .wr_rise(wr_rise),
    .ser_vld(ser_vld), .par_vld(par_vld), .par_kind(par_kind),
    .rd_pulse(rd_pulse), .byte_vld(byte_vld_o),
    .ser_active(ser_active), .ser_pol(ser_pol)
);

// File: tb/sim_hostcmd_port.sv
module sim_hostcmd_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode, cs_n, wr_n, dw_n, rd_n;
    logic [7:0] bus;
    logic [7:0] byte_o;
    logic       byte_kind_o, byte_vld_o, rd_pulse_o;

    int errs = 0;
    int checks = 0;
    int ev_n = 0;
    int rd_cnt = 0;
    logic [7:0] ev_data = 8'h00;
    logic       ev_kind = 1'b0;

    always #2 clk = ~clk;

    hostcmd_port u0 (
        .clk(clk), .rst(rst), .mode_serial_i(mode), .cs_n_i(cs_n),
        .wr_n_i(wr_n), .dw_n_i(dw_n), .rd_n_i(rd_n), .bus_i(bus),
        .byte_o(byte_o), .byte_kind_o(byte_kind_o),
        .byte_vld_o(byte_vld_o), .rd_pulse_o(rd_pulse_o)
    );

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld_o) begin
                ev_n    <= ev_n + 1;
                ev_data <= byte_o;
                ev_kind <= byte_kind_o;
            end
            if (rd_pulse_o) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit; fall_mode selects a high idle clock
    task automatic ser_bit(input logic b, input logic fall_mode);
        bus[7] = b;
        idle(3);
        bus[6] = ~fall_mode;
        idle(3);
        bus[6] = fall_mode;
        idle(3);
    endtask

    task automatic ser_byte(input logic [7:0] v, input logic fall_mode);
        for (int i = 7; i >= 0; i--) ser_bit(v[i], fall_mode);
    endtask

    task automatic ser_begin(input logic fall_mode);
        bus[6] = fall_mode;
        idle(4);
        cs_n = 1'b0;
        idle(4);
    endtask

    task automatic ser_end();
        cs_n = 1'b1;
        idle(6);
    endtask

    task automatic expect_byte(input string req, input int n0, input logic [7:0] v, input logic k);
        idle(6);
        chk(ev_n == n0 + 1, req, ev_n - n0, 1);
        chk(ev_data == v, req, ev_data, v);
        chk(ev_kind == k, req, ev_kind, k);
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 1'b0; cs_n = 1'b1; wr_n = 1'b1; dw_n = 1'b1; rd_n = 1'b1; bus = 8'h00;
        idle(5);
        chk(byte_vld_o == 1'b0, "R1 vld in reset", byte_vld_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(byte_o == 8'h00, "R1 byte after reset", byte_o, 0);
        chk(byte_vld_o == 1'b0, "R1 vld after reset", byte_vld_o, 0);
        chk(rd_pulse_o == 1'b0, "R1 rd after reset", rd_pulse_o, 0);
    endtask

    task automatic t_par_wr();
        int n0 = ev_n;
        cs_n = 1'b0; bus = 8'h9E; idle(3);
        wr_n = 1'b0; idle(3); wr_n = 1'b1;
        expect_byte("R6 wr capture", n0, 8'h9E, 1'b0);
        cs_n = 1'b1; idle(4);
    endtask

    task automatic t_par_dw();
        int n0 = ev_n;
        cs_n = 1'b0; bus = 8'h17; idle(3);
        dw_n = 1'b0; idle(3); dw_n = 1'b1;
        expect_byte("R7 dw capture", n0, 8'h17, 1'b1);
        n0 = ev_n;
        bus = 8'h66; idle(3);
        wr_n = 1'b0; dw_n = 1'b0; idle(3); wr_n = 1'b1; dw_n = 1'b1;
        expect_byte("R7 wr wins", n0, 8'h66, 1'b0);
        cs_n = 1'b1; idle(4);
    endtask

    task automatic t_par_gate();
        int n0 = ev_n;
        int r0 = rd_cnt;
        cs_n = 1'b1; bus = 8'hF0; idle(3);
        wr_n = 1'b0; idle(3); wr_n = 1'b1; idle(3);
        dw_n = 1'b0; idle(3); dw_n = 1'b1; idle(3);
        rd_n = 1'b0; idle(3); rd_n = 1'b1; idle(6);
        chk(ev_n == n0, "R8 no byte while deselected", ev_n - n0, 0);
        chk(rd_cnt == r0, "R8 no read while deselected", rd_cnt - r0, 0);
        chk(byte_o == 8'h66, "R8 byte unchanged", byte_o, 8'h66);
    endtask

    task automatic t_rd();
        int r0 = rd_cnt;
        cs_n = 1'b0; idle(3);
        rd_n = 1'b0; idle(6);
        chk(rd_cnt == r0 + 1, "R9 one-cycle read pulse", rd_cnt - r0, 1);
        rd_n = 1'b1; idle(4);
        chk(rd_cnt == r0 + 1, "R9 no pulse on release", rd_cnt - r0, 1);
        cs_n = 1'b1; idle(4);
    endtask

    task automatic t_par_mode();
        int n0 = ev_n;
        cs_n = 1'b0; idle(3);
        for (int i = 0; i < 16; i++) begin
            bus[7] = i[1]; bus[6] = i[0]; idle(3);
        end
        chk(ev_n == n0, "R10 serial pins idle in parallel mode", ev_n - n0, 0);
        cs_n = 1'b1; idle(4);
    endtask

    task automatic t_ser_rise();
        int n0;
        ser_begin(1'b0);
        n0 = ev_n;
        ser_byte(8'hA5, 1'b0);
        expect_byte("R2 rising-edge byte", n0, 8'hA5, 1'b0);
        n0 = ev_n;
        ser_byte(8'h3C, 1'b0);
        expect_byte("R4 second byte rising", n0, 8'h3C, 1'b0);
        ser_end();
    endtask

    task automatic t_ser_fall();
        int n0;
        ser_begin(1'b1);
        n0 = ev_n;
        ser_byte(8'h5A, 1'b1);
        expect_byte("R3 falling-edge byte", n0, 8'h5A, 1'b0);
        n0 = ev_n;
        ser_byte(8'hC3, 1'b1);
        expect_byte("R4 second byte falling", n0, 8'hC3, 1'b0);
        ser_end();
    endtask

    task automatic t_ser_abort();
        int n0;
        ser_begin(1'b0);
        n0 = ev_n;
        for (int i = 0; i < 5; i++) ser_bit(1'b1, 1'b0);
        ser_end();
        chk(ev_n == n0, "R5 partial byte dropped", ev_n - n0, 0);
        ser_begin(1'b0);
        n0 = ev_n;
        ser_byte(8'h81, 1'b0);
        expect_byte("R5 fresh byte after abort", n0, 8'h81, 1'b0);
        ser_end();
    endtask

    task automatic t_ser_gate();
        int n0 = ev_n;
        cs_n = 1'b1;
        for (int i = 0; i < 10; i++) ser_bit(i[0], 1'b0);
        chk(ev_n == n0, "R8 serial clock ignored while deselected", ev_n - n0, 0);
        ser_begin(1'b0);
        ser_byte(8'h42, 1'b0);
        expect_byte("R8 clean byte after deselected clocks", n0, 8'h42, 1'b0);
        ser_end();
    endtask

    task automatic t_ser_mode();
        int n0;
        bus[6] = 1'b0;
        ser_begin(1'b0);
        n0 = ev_n;
        wr_n = 1'b0; idle(3); wr_n = 1'b1; idle(3);
        dw_n = 1'b0; idle(3); dw_n = 1'b1; idle(6);
        chk(ev_n == n0, "R10 write strobes ignored in serial mode", ev_n - n0, 0);
        ser_end();
    endtask

    initial begin
        t_reset();
        t_par_wr();
        t_par_dw();
        t_par_gate();
        t_rd();
        t_par_mode();
        mode = 1'b1; bus = 8'h00; idle(6);
        t_ser_rise();
        t_ser_fall();
        t_ser_abort();
        t_ser_gate();
        t_ser_mode();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule